// File: doc/BRIEF.md
# Dual-Rail HDB3 Line Decoder with Coding Alarm

This block takes a bipolar line that has already been sliced into two logic rails, one that is high for a positive pulse and one that is high for a negative pulse. Both rails are sampled on the tributary clock. The block turns the line back into NRZ data. It tracks the polarity of successive marks, so it can tell an ordinary alternating mark from a same-polarity violation pulse. When a violation completes a legal four-symbol substitution, the block writes four zeros over the whole substitution in its output pipeline.

Any symbol that breaks the line code raises a single registered alarm line for one clock. Three kinds of error share that line:
- a same-polarity pulse that does not close a legal substitution;
- a zero run longer than a configurable limit;
- a malformed substitution, which covers both a violation whose polarity repeats the previous violation and a cycle with both rails high.

Alarms stay quiet after reset until the first mark has given the decoder a polarity reference.

Top module: `hdb3_line_decoder`

## Requirements
- R1: The rails are encoded as follows: pos_i=1, neg_i=0 is a positive mark; pos_i=0, neg_i=1 is a negative mark; both low is a space; both high is an invalid symbol. Sampling happens on the rising edge of clk. A space decodes to 0 and an alternating mark decodes to 1. The bit for a symbol sampled on edge k is visible on nrz_o from just after edge k+3 until edge k+4, so the latency is four clocks including the sampling edge.
- R2: A mark with the same polarity as the previous mark, preceded by exactly three spaces since that mark (the pattern 000V), is legal. It gives no alarm, and all four of its symbols leave nrz_o as 0.
- R3: A same-polarity mark preceded by exactly two spaces, where the mark before those spaces alternated normally (the pattern B00V), is legal. It gives no alarm, and B, the two spaces and V all leave nrz_o as 0.
- R4: A same-polarity mark preceded by zero or one space since the previous mark raises the alarm and decodes to 1.
- R5: A same-polarity mark whose polarity equals that of the previous same-polarity mark is a malformed substitution, even when the space count fits. It raises the alarm and decodes to 1, and the spaces before it stay 0.
- R6: A cycle with both rails high raises the alarm and decodes to 1. It clears the space count and leaves the last-mark polarity unchanged.
- R7: When the space run grows past ZERO_LIMIT (default 4), the alarm fires once, on space number ZERO_LIMIT+1. Further spaces raise no alarm until a mark or an invalid symbol arrives.
- R8: alarm_o is a register. It is high in the single cycle after the sampling edge of each offending symbol, and back-to-back offending symbols give back-to-back high cycles.
- R9: The asynchronous active-low reset clears the output pipeline (nrz_o=0), alarm_o, the polarity history and the space count. No alarm is raised until the first mark after reset, and that first mark is taken as the polarity reference without an alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tributary clock; rails sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Positive pulse rail |
| neg_i | input | 1 | Negative pulse rail |
| nrz_o | output | 1 | Decoded NRZ data, four clocks of latency |
| alarm_o | output | 1 | One-cycle coding-violation alarm, active high |

## Verification
The bench builds the decoder with the default ZERO_LIMIT of 4. With that value a five-space run produces an alarm inside a short vector table, and a run one longer shows that the alarm does not repeat. The substitution length is fixed at four symbols, so the same table can pass through both substitution shapes and a repeated violation polarity, with the four-clock output alignment checked on every symbol. Directed steps then reset the decoder with data still in flight, and show that neither an invalid symbol nor a long space run raises an alarm before the first mark.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;

    // Symbol code formed as {pos_rail, neg_rail}
    typedef enum logic [1:0] {
        SYM_SPACE = 2'b00,
        SYM_MINUS = 2'b01,
        SYM_PLUS  = 2'b10,
        SYM_BOTH  = 2'b11
    } sym_e;

    // Length of a substitution pattern in symbols
    localparam int unsigned SUB_LEN      = 4;
    // Spaces before V in the all-zero pattern and in the bipolar pattern
    localparam int unsigned RUN_FULL_SUB = SUB_LEN - 1;
    localparam int unsigned RUN_BIP_SUB  = SUB_LEN - 2;

endpackage

// File: rtl/hdb3_sym_classify.sv
module hdb3_sym_classify
    import hdb3_pkg::*;
(
    input  logic pos_i,
    input  logic neg_i,
    output sym_e sym_o
);

    always_comb begin
        case ({pos_i, neg_i})
            2'b10:   sym_o = SYM_PLUS;
            2'b01:   sym_o = SYM_MINUS;
            2'b11:   sym_o = SYM_BOTH;
            default: sym_o = SYM_SPACE;
        endcase
    end

endmodule

// File: rtl/hdb3_rule_tracker.sv
module hdb3_rule_tracker
    import hdb3_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  sym_e sym_i,
    output logic data_bit_o,
    output logic legal_v_o,
    output logic alarm_o
);

    localparam int unsigned     RUN_W    = $clog2(ZERO_LIMIT + 2);
    localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(ZERO_LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_LIM  = RUN_W'(ZERO_LIMIT);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_FULL_SUB);
    localparam logic [RUN_W-1:0] RUN_BIP  = RUN_W'(RUN_BIP_SUB);

    typedef struct packed {
        logic             seen;      // a mark has arrived since reset
        logic             last_pol;  // 1 = last mark positive
        logic             vref_ok;   // a violation has arrived since reset
        logic             last_vpol; // polarity of that violation
        logic [RUN_W-1:0] run;       // spaces since last mark, saturating
        logic             alarm;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       mark_pol;
    logic       run_fits;
    logic       alt_fits;

    always_comb begin
        st_d       = st_q;
        st_d.alarm = 1'b0;
        data_bit_o = 1'b0;
        legal_v_o  = 1'b0;
        mark_pol   = (sym_i == SYM_PLUS);
        run_fits   = (st_q.run == RUN_FULL) || (st_q.run == RUN_BIP);
        alt_fits   = !st_q.vref_ok || (mark_pol != st_q.last_vpol);

        case (sym_i)
            SYM_SPACE: begin
                if (st_q.run != RUN_SAT) begin
                    st_d.run = st_q.run + 1'b1;
                end
                if (st_q.seen && (st_q.run == RUN_LIM)) begin
                    st_d.alarm = 1'b1;
                end
            end
            SYM_BOTH: begin
                data_bit_o = 1'b1;
                st_d.run   = '0;
                st_d.alarm = st_q.seen;
            end
            default: begin
                data_bit_o    = 1'b1;
                st_d.run      = '0;
                st_d.last_pol = mark_pol;
                if (!st_q.seen) begin
                    st_d.seen = 1'b1;
                end else if (mark_pol == st_q.last_pol) begin
                    st_d.vref_ok   = 1'b1;
                    st_d.last_vpol = mark_pol;
                    if (run_fits && alt_fits) begin
                        legal_v_o  = 1'b1;
                        data_bit_o = 1'b0;
                    end else begin
                        st_d.alarm = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_o = st_q.alarm;

endmodule

// File: rtl/hdb3_zero_restore.sv
module hdb3_zero_restore #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic legal_v_i,
    output logic nrz_o
);

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } rs_state_t;

    rs_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = bit_i;
        for (int i = 1; i < DEPTH; i++) begin
            // a legal violation blanks the symbols that formed its pattern
            st_d.pipe[i] = legal_v_i ? 1'b0 : st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nrz_o = st_q.pipe[DEPTH-1];

endmodule

// File: rtl/hdb3_line_decoder.sv
module hdb3_line_decoder
    import hdb3_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    output logic nrz_o,
    output logic alarm_o
);

    sym_e sym_w;
    logic data_bit_w;
    logic legal_v_w;

    hdb3_sym_classify u_classify (
        .pos_i (pos_i),
        .neg_i (neg_i),
        .sym_o (sym_w)
    );

    hdb3_rule_tracker #(
        .ZERO_LIMIT (ZERO_LIMIT)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_i      (sym_w),
        .data_bit_o (data_bit_w),
        .legal_v_o  (legal_v_w),
        .alarm_o    (alarm_o)
    );

    hdb3_zero_restore #(
        .DEPTH (SUB_LEN)
    ) u_restore (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (data_bit_w),
        .legal_v_i (legal_v_w),
        .nrz_o     (nrz_o)
    );

endmodule

// File: rtl/hdb3_line_decoder_chk.sv
module hdb3_line_decoder_chk #(
    parameter int unsigned ZERO_LIMIT = 4
) (
    input logic clk,
    input logic rst_n,
    input logic pos_i,
    input logic neg_i,
    input logic nrz_o,
    input logic alarm_o
);

    localparam int unsigned      CW    = $clog2(ZERO_LIMIT + 2);
    localparam logic [CW-1:0]    C_SAT = CW'(ZERO_LIMIT + 1);
    localparam logic [CW-1:0]    C_LIM = CW'(ZERO_LIMIT);
    localparam logic [CW-1:0]    C_BIP = CW'(hdb3_pkg::RUN_BIP_SUB);

    logic          c_seen_q;
    logic          c_pol_q;
    logic [CW-1:0] c_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_seen_q <= 1'b0;
            c_pol_q  <= 1'b0;
            c_run_q  <= '0;
        end else if (pos_i ^ neg_i) begin
            c_seen_q <= 1'b1;
            c_pol_q  <= pos_i;
            c_run_q  <= '0;
        end else if (pos_i && neg_i) begin
            c_run_q  <= '0;
        end else if (c_run_q != C_SAT) begin
            c_run_q  <= c_run_q + 1'b1;
        end
    end

    AST_SPACE_DECODES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pos_i && !neg_i, 4) |-> !nrz_o); // R1

    AST_SHORT_RUN_SAME_POL: assert property (@(posedge clk) disable iff (!rst_n)
        $past((pos_i ^ neg_i) && c_seen_q && (pos_i == c_pol_q) && (c_run_q < C_BIP)) |-> alarm_o); // R4

    AST_BOTH_RAILS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pos_i && neg_i && c_seen_q) |-> alarm_o); // R6

    AST_LONG_RUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pos_i && !neg_i && c_seen_q && (c_run_q == C_LIM)) |-> alarm_o); // R7

    AST_RUN_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && $past(!pos_i && !neg_i)) |-> !$past(alarm_o)); // R8

    AST_QUIET_UNTIL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> c_seen_q); // R9

endmodule

bind hdb3_line_decoder hdb3_line_decoder_chk #(
    .ZERO_LIMIT (ZERO_LIMIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pos_i   (pos_i),
    .neg_i   (neg_i),
    .nrz_o   (nrz_o),
    .alarm_o (alarm_o)
);

// File: tb/hdb3_line_decoder_tb_top.sv
`timescale 1ns/1ps
module hdb3_line_decoder_tb_top;

    localparam int unsigned ZERO_LIMIT = 4;
    localparam int          NVEC       = 46;

    // entry: [7] pos, [6] neg, [5] expected alarm, [4] expected final nrz, [3:0] requirement
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b00_0_0_1001, 8'b00_0_0_1001, 8'b00_0_0_1001, // R9 spaces before first mark
        8'b00_0_0_1001, 8'b00_0_0_1001, 8'b00_0_0_1001, // R9 run past limit, still quiet
        8'b10_0_1_1001,                                 // R9 first mark sets reference
        8'b01_0_1_0001, 8'b00_0_0_0001, 8'b10_0_1_0001, // R1 plain alternation
        8'b00_0_0_0010, 8'b00_0_0_0010, 8'b00_0_0_0010, // R2 000 ...
        8'b10_0_0_0010,                                 // R2 ... V removed
        8'b01_0_0_0011, 8'b00_0_0_0011, 8'b00_0_0_0011, // R3 B 0 0 ...
        8'b01_0_0_0011,                                 // R3 ... V removed
        8'b10_0_1_0001,                                 // R1
        8'b10_1_1_0100,                                 // R4 same polarity, no spaces
        8'b01_0_1_0001, 8'b10_0_1_0001,                 // R1
        8'b00_0_0_0101, 8'b00_0_0_0101, 8'b00_0_0_0101, // R5 spaces kept
        8'b10_1_1_0101,                                 // R5 repeated violation polarity
        8'b01_0_1_0001,                                 // R1
        8'b11_1_1_0110,                                 // R6 both rails
        8'b10_0_1_0110,                                 // R6 polarity kept from before
        8'b00_0_0_0111, 8'b00_0_0_0111, 8'b00_0_0_0111, // R7
        8'b00_0_0_0111, 8'b00_1_0_0111,                 // R7 fifth space flags
        8'b00_0_0_0111, 8'b00_0_0_0111,                 // R7 no repeat
        8'b01_0_1_0001,                                 // R1
        8'b01_1_1_0100,                                 // R4
        8'b01_1_1_1000,                                 // R8 back-to-back alarm
        8'b10_0_1_0001,                                 // R1
        8'b00_0_0_0111, 8'b00_0_0_0111, 8'b00_0_0_0111,
        8'b00_0_0_0111, 8'b00_1_0_0111, 8'b00_0_0_0111  // R7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_i = 1'b0;
    logic neg_i = 1'b0;
    logic nrz_o;
    logic alarm_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hdb3_line_decoder #(
        .ZERO_LIMIT (ZERO_LIMIT)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_i   (pos_i),
        .neg_i   (neg_i),
        .nrz_o   (nrz_o),
        .alarm_o (alarm_o)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // called at a falling edge; drives a symbol, then checks at the next falling edge
    task automatic send(input logic p, input logic n, input logic exp_alarm,
                        input logic exp_nrz, input string tag);
        pos_i = p;
        neg_i = n;
        @(posedge clk);
        @(negedge clk);
        check(alarm_o, exp_alarm, {tag, " alarm"});
        check(nrz_o, exp_nrz, {tag, " nrz"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(nrz_o, 1'b0, "R9 reset nrz");
        check(alarm_o, 1'b0, "R9 reset alarm");

        // vector table; nrz lags the driven symbol by three table steps (R1)
        for (int idx = 0; idx < NVEC; idx++) begin
            logic exp_n;
            int   rq;
            exp_n = (idx >= 3) ? VEC[idx-3][4] : 1'b0;
            rq    = (idx >= 3) ? int'(VEC[idx-3][3:0]) : 9;
            send(VEC[idx][7], VEC[idx][6], VEC[idx][5], exp_n,
                 $sformatf("R%0d/R%0d vec %0d", VEC[idx][3:0], rq, idx));
        end

        // leave a 1 in flight and a negative reference, then reset (R9)
        send(1'b0, 1'b1, 1'b0, VEC[NVEC-3][4], "R1 pre-reset mark");
        pos_i = 1'b0;
        neg_i = 1'b0;
        rst_n = 1'b0;
        #1;
        check(nrz_o, 1'b0, "R9 async clear nrz");
        check(alarm_o, 1'b0, "R9 async clear alarm");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        send(1'b1, 1'b1, 1'b0, 1'b0, "R9 both rails before mark");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R9 space 1");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R9 space 2");
        send(1'b0, 1'b0, 1'b0, 1'b1, "R6 space 3, invalid symbol emerges");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R9 space 4");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R9 space 5 quiet");
        send(1'b0, 1'b0, 1'b0, 1'b0, "R9 space 6");
        send(1'b0, 1'b1, 1'b0, 1'b0, "R9 first mark after reset");
        send(1'b0, 1'b1, 1'b1, 1'b0, "R4 reference from first mark");
        send(1'b1, 1'b0, 1'b0, 1'b0, "R1 alternating mark");
        send(1'b0, 1'b0, 1'b0, 1'b1, "R1 latency first mark");
        send(1'b0, 1'b0, 1'b0, 1'b1, "R4 flagged mark decodes 1");
        send(1'b0, 1'b0, 1'b0, 1'b1, "R1 latency last mark");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule